// File: doc/BRIEF.md
# Calendar Alarm Comparator with Subsecond Mask

This block watches a running BCD calendar (seconds, minutes, hours with an afternoon bit, day of month and day of week) together with a 15-bit subsecond down-counter. It compares them against a stored alarm setting. The comparison is evaluated once for each subsecond tick. When every field that takes part agrees, a sticky alarm flag is set. The flag can raise an interrupt request, and it drives an output pin whose active level is selectable.

Any calendar field can be excluded from the comparison by its own mask bit. The day field holds either a BCD day of month or a weekday code, chosen by a select bit. The number of low subsecond bits that take part is set by a 4-bit level.

The alarm setting is held inside the block and is loaded through a write strobe. A load is taken only while the write-allowed status is high, and that status is high only while the alarm is disabled.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, `alarm_flag`, `alarm_irq` and the stored alarm setting are zero, `wr_ok` is 1, and `alarm_pin` shows the flag's idle level.
- R2: With `alm_en` high, `alarm_flag` is 1 after the rising edge at which `tick` is sampled high and every unmasked field matches. Without `tick`, or with `alm_en` low, the flag does not set.
- R3: `cfg_mask` excludes fields from the comparison. Bit 0 excludes seconds, bit 1 minutes, bit 2 hours together with the PM bit, and bit 3 the day field. A masked field always counts as matching.
- R4: With `cfg_wday_sel` = 1, the day field compares `cfg_day[2:0]` against `cur_wday` (1 = Monday up to 7 = Sunday). With `cfg_wday_sel` = 0, it compares the 8-bit BCD `cfg_day` against `cur_date`.
- R5: The hour comparison includes the PM bit, so 11 AM and 11 PM are different hours in 12-hour use.
- R6: The subsecond level L selects which bits are compared. L = 0 compares no bits, L = 1 to 14 compares bits [L-1:0], and L = 15 compares all 15 bits.
- R7: `alarm_flag` stays set until `flag_clr` is sampled high. If a new match occurs in the same cycle as a clear, the flag stays set.
- R8: `alarm_irq` is high only while `alarm_flag` and `irq_en` are both high.
- R9: `wr_ok` is 0 one cycle after `alm_en` is sampled high. It returns to 1 on the second edge after `alm_en` is sampled low.
- R10: A `cfg_we` strobe while `wr_ok` is 0 leaves the stored alarm setting unchanged.
- R11: `alarm_pin` equals `alarm_flag` when `pin_active_low` = 0, and equals its inverse when `pin_active_low` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Subsecond tick; the comparison is evaluated when high |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_pm | input | 1 | Current PM bit |
| cur_date | input | 8 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday code, 1 to 7 |
| cur_subsec | input | 15 | Current subsecond counter |
| cfg_we | input | 1 | Load strobe for the alarm setting |
| cfg_sec | input | 8 | Alarm seconds, BCD |
| cfg_min | input | 8 | Alarm minutes, BCD |
| cfg_hour | input | 8 | Alarm hours, BCD |
| cfg_pm | input | 1 | Alarm PM bit |
| cfg_day | input | 8 | Alarm day: BCD date, or weekday code in bits [2:0] |
| cfg_wday_sel | input | 1 | 1 selects a weekday comparison, 0 selects a date comparison |
| cfg_mask | input | 4 | Field masks: [0] seconds, [1] minutes, [2] hours, [3] day |
| cfg_ss | input | 15 | Alarm subsecond value |
| cfg_ss_lvl | input | 4 | Subsecond compare level |
| alm_en | input | 1 | Alarm enable |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Flag clear strobe |
| pin_active_low | input | 1 | 1 drives the pin low while the flag is set |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Interrupt request |
| wr_ok | output | 1 | Alarm setting may be loaded |
| alarm_pin | output | 1 | Alarm output after the polarity choice |

## Verification
The comparison is first exercised with a full match and with a single subsecond bit wrong. This separates a true match from a near miss, and a tick from an idle cycle.

Next, the stimulus masks all fields, then leaves only seconds unmasked. This shows that each mask bit, in its stated position, really removes its field.

The day field is tried with the weekday code equal while the date differs, and the other way round. This distinguishes the two modes. Equal hours with opposite PM bits show that the PM bit takes part in the hour comparison.

Subsecond levels 4 and 14 are tried with values that differ only just above, or just inside, the compared range. These patterns pin down where the compare boundary lies.

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
  parameter int SS_W  = 15,
  parameter int FLD_W = 8,
  parameter int WD_W  = 3,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [FLD_W-1:0] cur_sec,
  input  logic [FLD_W-1:0] cur_min,
  input  logic [FLD_W-1:0] cur_hour,
  input  logic             cur_pm,
  input  logic [FLD_W-1:0] cur_date,
  input  logic [WD_W-1:0]  cur_wday,
  input  logic [SS_W-1:0]  cur_subsec,
  input  logic             cfg_we,
  input  logic [FLD_W-1:0] cfg_sec,
  input  logic [FLD_W-1:0] cfg_min,
  input  logic [FLD_W-1:0] cfg_hour,
  input  logic             cfg_pm,
  input  logic [FLD_W-1:0] cfg_day,
  input  logic             cfg_wday_sel,
  input  logic [3:0]       cfg_mask,
  input  logic [SS_W-1:0]  cfg_ss,
  input  logic [LVL_W-1:0] cfg_ss_lvl,
  input  logic             alm_en,
  input  logic             irq_en,
  input  logic             flag_clr,
  input  logic             pin_active_low,
  output logic             alarm_flag,
  output logic             alarm_irq,
  output logic             wr_ok,
  output logic             alarm_pin
);

  localparam logic [SS_W:0] ONE = 1;

  logic [FLD_W-1:0] a_sec, a_min, a_hour, a_day;
  logic             a_pm, a_wsel;
  logic [3:0]       a_msk;
  logic [SS_W-1:0]  a_ss;
  logic [LVL_W-1:0] a_lvl;
  logic             en_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_sec <= '0; a_min <= '0; a_hour <= '0; a_day <= '0;
      a_pm  <= 1'b0; a_wsel <= 1'b0; a_msk <= '0;
      a_ss  <= '0; a_lvl <= '0;
    end else if (cfg_we && wr_ok) begin
      a_sec <= cfg_sec; a_min <= cfg_min; a_hour <= cfg_hour; a_day <= cfg_day;
      a_pm  <= cfg_pm; a_wsel <= cfg_wday_sel; a_msk <= cfg_mask;
      a_ss  <= cfg_ss; a_lvl <= cfg_ss_lvl;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_d  <= 1'b0;
      wr_ok <= 1'b1;
    end else begin
      en_d  <= alm_en;
      wr_ok <= !alm_en && !en_d;
    end

  logic [SS_W:0]   ss_span;
  logic [SS_W-1:0] ss_bits;
  logic            m_sec, m_min, m_hour, m_day, m_ss, hit;

  assign ss_span = (ONE << a_lvl) - ONE;
  assign ss_bits = ss_span[SS_W-1:0];

  assign m_sec  = a_msk[0] || (a_sec == cur_sec);
  assign m_min  = a_msk[1] || (a_min == cur_min);
  assign m_hour = a_msk[2] || ((a_hour == cur_hour) && (a_pm == cur_pm));
  assign m_day  = a_msk[3] || (a_wsel ? (a_day[WD_W-1:0] == cur_wday)
                                      : (a_day == cur_date));
  assign m_ss   = ((a_ss ^ cur_subsec) & ss_bits) == '0;
  assign hit    = tick && alm_en && m_sec && m_min && m_hour && m_day && m_ss;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        alarm_flag <= 1'b0;
    else if (hit)      alarm_flag <= 1'b1;
    else if (flag_clr) alarm_flag <= 1'b0;

  assign alarm_irq = alarm_flag && irq_en;
  assign alarm_pin = alarm_flag ^ pin_active_low;

  // R2
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(tick && alm_en));
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_flag && !flag_clr |=> alarm_flag);
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !tick |=> !alarm_flag);
  // R9
  wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alm_en |=> !wr_ok);
  // R9
  wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alm_en) ##1 !alm_en |=> wr_ok);
  // R10
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !wr_ok |=> $stable(a_ss) && $stable(a_sec) && $stable(a_msk) && $stable(a_lvl));

endmodule

// File: tb/sim_alarm_match_unit.sv
module sim_alarm_match_unit;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [7:0] cur_sec = 8'h56, cur_min = 8'h34, cur_hour = 8'h12, cur_date = 8'h15;
  logic cur_pm = 0;
  logic [2:0] cur_wday = 3'd3;
  logic [14:0] cur_subsec = 15'h1234;
  logic cfg_we = 0, cfg_pm = 0, cfg_wday_sel = 0;
  logic [7:0] cfg_sec = 0, cfg_min = 0, cfg_hour = 0, cfg_day = 0;
  logic [3:0] cfg_mask = 0, cfg_ss_lvl = 0;
  logic [14:0] cfg_ss = 0;
  logic alm_en = 0, irq_en = 0, flag_clr = 0, pin_active_low = 0;
  logic alarm_flag, alarm_irq, wr_ok, alarm_pin;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alarm_match_unit u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1; step(); tick = 0;
  endtask

  task automatic arm(input logic [7:0] s, m, h, input logic pm,
                     input logic [7:0] d, input logic ws, input logic [3:0] msk,
                     input logic [14:0] ss, input logic [3:0] lvl);
    alm_en = 0; flag_clr = 1; step(); step(); flag_clr = 0;
    cfg_sec = s; cfg_min = m; cfg_hour = h; cfg_pm = pm; cfg_day = d;
    cfg_wday_sel = ws; cfg_mask = msk; cfg_ss = ss; cfg_ss_lvl = lvl;
    cfg_we = 1; step(); cfg_we = 0;
    alm_en = 1; step();
  endtask

  task automatic clr();
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 flag", alarm_flag, 0);
    chk("R1 irq", alarm_irq, 0);
    chk("R1 wr_ok", wr_ok, 1);
    chk("R1 pin", alarm_pin, 0);
  endtask

  task automatic t_basic();
    arm(8'h56, 8'h34, 8'h12, 0, 8'h15, 0, 4'b0000, 15'h1234, 4'd15);
    chk("R9 wr_ok low after enable", wr_ok, 0);
    step();
    chk("R2 no tick no flag", alarm_flag, 0);
    cur_subsec = 15'h1235; pulse_tick();
    chk("R6 full subsecond mismatch", alarm_flag, 0);
    cur_subsec = 15'h1234; pulse_tick();
    chk("R2 full match sets flag", alarm_flag, 1);
    chk("R8 irq masked", alarm_irq, 0);
    irq_en = 1; #1;
    chk("R8 irq enabled", alarm_irq, 1);
    chk("R11 pin active high", alarm_pin, 1);
    pin_active_low = 1; #1;
    chk("R11 pin active low", alarm_pin, 0);
    pin_active_low = 0;
    step(); step();
    chk("R7 flag sticky", alarm_flag, 1);
    flag_clr = 1; tick = 1; step(); flag_clr = 0; tick = 0;
    chk("R7 match beats clear", alarm_flag, 1);
    clr();
    chk("R7 clear", alarm_flag, 0);
    chk("R8 irq follows flag", alarm_irq, 0);
    irq_en = 0;
  endtask

  task automatic t_lock();
    cfg_sec = 8'h00; cfg_mask = 4'b0000; cfg_we = 1; step(); cfg_we = 0;
    pulse_tick();
    chk("R10 locked write ignored", alarm_flag, 1);
    clr();
    alm_en = 0; step();
    chk("R9 wr_ok still low one edge after disable", wr_ok, 0);
    step();
    chk("R9 wr_ok high two edges after disable", wr_ok, 1);
    pulse_tick();
    chk("R2 disabled no flag", alarm_flag, 0);
  endtask

  task automatic t_mask();
    arm(8'h00, 8'h00, 8'h00, 1, 8'h01, 0, 4'b1111, 15'h0, 4'd0);
    pulse_tick();
    chk("R3 all masked match", alarm_flag, 1);
    arm(8'h00, 8'h00, 8'h00, 1, 8'h01, 0, 4'b1110, 15'h0, 4'd0);
    pulse_tick();
    chk("R3 seconds unmasked mismatch", alarm_flag, 0);
    cur_sec = 8'h00; pulse_tick();
    chk("R3 seconds unmasked match", alarm_flag, 1);
    cur_sec = 8'h56;
  endtask

  task automatic t_day();
    arm(8'h56, 8'h34, 8'h12, 0, 8'h03, 1, 4'b0000, 15'h0, 4'd0);
    pulse_tick();
    chk("R4 weekday match", alarm_flag, 1);
    clr();
    cur_wday = 3'd4; pulse_tick();
    chk("R4 weekday mismatch", alarm_flag, 0);
    arm(8'h56, 8'h34, 8'h12, 0, 8'h15, 0, 4'b0000, 15'h0, 4'd0);
    pulse_tick();
    chk("R4 date match ignores weekday", alarm_flag, 1);
    cur_wday = 3'd3;
  endtask

  task automatic t_pm();
    arm(8'h00, 8'h00, 8'h11, 1, 8'h00, 0, 4'b1011, 15'h0, 4'd0);
    cur_hour = 8'h11; cur_pm = 0; pulse_tick();
    chk("R5 AM vs PM mismatch", alarm_flag, 0);
    cur_pm = 1; pulse_tick();
    chk("R5 PM match", alarm_flag, 1);
    cur_hour = 8'h12; cur_pm = 0;
  endtask

  task automatic t_lvl();
    arm(8'h00, 8'h00, 8'h00, 0, 8'h00, 0, 4'b1111, 15'h0005, 4'd4);
    cur_subsec = 15'h7FF5; pulse_tick();
    chk("R6 level 4 upper bits ignored", alarm_flag, 1);
    clr();
    cur_subsec = 15'h7FF6; pulse_tick();
    chk("R6 level 4 low bit differs", alarm_flag, 0);
    arm(8'h00, 8'h00, 8'h00, 0, 8'h00, 0, 4'b1111, 15'h0005, 4'd14);
    cur_subsec = 15'h4005; pulse_tick();
    chk("R6 level 14 bit 14 ignored", alarm_flag, 1);
    clr();
    cur_subsec = 15'h0015; pulse_tick();
    chk("R6 level 14 bit 4 compared", alarm_flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset();
    t_basic();
    t_lock();
    t_mask();
    t_day();
    t_pm();
    t_lvl();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule